// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block is the hazard controller of an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. It works out where each ALU source operand of the instruction in execute comes from. An operand can come from the register file, from the result waiting in the execute/memory register, or from the result waiting in the memory/write-back register. It also decides when the front of the pipeline must pause because a load's data is not yet available.

For every pipeline register that can produce a result, the controller receives two things: the two candidate destination fields, and a flag that tells which of the two the instruction writes. Register-register ALU operations write the `rd`-style field. Immediate ALU operations and loads write the `rt`-style field. The controller resolves the real destination itself and compares it with the source numbers of the instructions in execute and in decode.

A load followed at once by a consumer costs exactly one cycle. In that cycle the program counter and the fetch/decode register hold, and the decode/execute register takes a bubble. On the next cycle the load sits in memory/write-back and its data is bypassed from there. The register file writes before it reads, so decode-stage reads of a register being written back need no help from this block. The block is purely combinational and contains no state.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: When the execute/memory entry has write enable set, is not a load, and has a resolved destination that is nonzero and equal to an execute source, that operand's select is 1 (execute/memory result).
- R2: When only the memory/write-back entry matches an execute source (write enable set, nonzero destination, load or not), that operand's select is 2 (memory/write-back result).
- R3: When both entries match the same source, the select is 1, because the younger result wins.
- R4: With no match, the select is 0 (register file). The value 3 never appears. Operand A follows the execute `rs` source and operand B follows the execute `rt` source, independently of each other.
- R5: A destination or source of register 0 never causes a bypass or a stall.
- R6: The resolved destination of an entry is its `rd` field when its uses-rd flag is 1, and its `rt` field otherwise. A match on the unused field has no effect.
- R7: When the decode/execute entry is a load with write enable and a nonzero destination equal to the decode `rs` or `rt` source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1. Otherwise all three are 0.
- R8: A non-load in decode/execute never causes a stall, even when its destination matches.
- R9: An entry with write enable clear never causes a bypass or a stall.
- R10: An execute/memory entry flagged as a load is never chosen as a bypass source (select 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_ADDR_W | First source register of the instruction in execute |
| ex_rt | input | REG_ADDR_W | Second source register of the instruction in execute |
| id_rs | input | REG_ADDR_W | First source register of the instruction in decode |
| id_rt | input | REG_ADDR_W | Second source register of the instruction in decode |
| idex_rd | input | REG_ADDR_W | rd field held in decode/execute |
| idex_rt | input | REG_ADDR_W | rt field held in decode/execute |
| idex_uses_rd | input | 1 | Decode/execute instruction writes its rd field |
| idex_wr_en | input | 1 | Decode/execute instruction writes a register |
| idex_is_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | REG_ADDR_W | rd field held in execute/memory |
| exmem_rt | input | REG_ADDR_W | rt field held in execute/memory |
| exmem_uses_rd | input | 1 | Execute/memory instruction writes its rd field |
| exmem_wr_en | input | 1 | Execute/memory instruction writes a register |
| exmem_is_load | input | 1 | Execute/memory instruction is a load |
| memwb_rd | input | REG_ADDR_W | rd field held in memory/write-back |
| memwb_rt | input | REG_ADDR_W | rt field held in memory/write-back |
| memwb_uses_rd | input | 1 | Memory/write-back instruction writes its rd field |
| memwb_wr_en | input | 1 | Memory/write-back instruction writes a register |
| fwd_a_sel | output | 2 | Operand A source: 0 register file, 1 execute/memory, 2 memory/write-back |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into decode/execute (write enable, memory write and load flag cleared) |

## Verification
The bench builds the block with the default register-number width of five bits. Its random phase draws every register field from only 0 to 3. That makes coincidences frequent: double matches, matches on the unused destination field, and matches on register 0 all show up. Directed cases walk one load-use sequence through its stall cycle and its later bypass from memory/write-back. The remaining directed cases pin down the priority and zero-register rules.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } opnd_src_e;

    localparam int N_PRODUCERS = 3;  // decode/execute, execute/memory, memory/write-back
    localparam int N_OPERANDS  = 2;

endpackage

// File: rtl/fwd_dest_pick.sv
module fwd_dest_pick #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rd_fld,
    input  logic [AW-1:0] rt_fld,
    input  logic          uses_rd,
    output logic [AW-1:0] dest
);
    // Register-register ops write rd; immediate ops and loads write rt (R6)
    always_comb begin
        dest = uses_rd ? rd_fld : rt_fld;
    end
endmodule

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exmem_dest,
    input  logic          exmem_wr_en,
    input  logic          exmem_is_load,
    input  logic [AW-1:0] memwb_dest,
    input  logic          memwb_wr_en,
    output opnd_src_e     sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic hit_exmem;
    logic hit_memwb;

    always_comb begin
        hit_exmem = exmem_wr_en && !exmem_is_load
                    && (exmem_dest != ZERO_REG) && (exmem_dest == src);
        hit_memwb = memwb_wr_en
                    && (memwb_dest != ZERO_REG) && (memwb_dest == src);
        unique case ({hit_exmem, hit_memwb})
            2'b10, 2'b11: sel = SRC_EXMEM;   // younger result wins (R3)
            2'b01:        sel = SRC_MEMWB;
            default:      sel = SRC_REGFILE;
        endcase
    end

    always_comb begin
        if (sel == SRC_MEMWB) begin
            p_memwb_hit_needs_write_r2: assert (memwb_wr_en && memwb_dest == src)
                else $error("memwb bypass without a matching write");
        end
        if (src == ZERO_REG) begin
            p_zero_src_regfile_r5: assert (sel == SRC_REGFILE)
                else $error("register 0 was bypassed");
        end
    end
endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] idex_dest,
    input  logic          idex_wr_en,
    input  logic          idex_is_load,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    output logic          stall
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic dep_hit;

    always_comb begin
        dep_hit = (idex_dest == id_rs) || (idex_dest == id_rt);
        stall   = idex_is_load && idex_wr_en && (idex_dest != ZERO_REG) && dep_hit;
    end
endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
    import fwd_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] ex_rs,
    input  logic [REG_ADDR_W-1:0] ex_rt,
    input  logic [REG_ADDR_W-1:0] id_rs,
    input  logic [REG_ADDR_W-1:0] id_rt,
    input  logic [REG_ADDR_W-1:0] idex_rd,
    input  logic [REG_ADDR_W-1:0] idex_rt,
    input  logic                  idex_uses_rd,
    input  logic                  idex_wr_en,
    input  logic                  idex_is_load,
    input  logic [REG_ADDR_W-1:0] exmem_rd,
    input  logic [REG_ADDR_W-1:0] exmem_rt,
    input  logic                  exmem_uses_rd,
    input  logic                  exmem_wr_en,
    input  logic                  exmem_is_load,
    input  logic [REG_ADDR_W-1:0] memwb_rd,
    input  logic [REG_ADDR_W-1:0] memwb_rt,
    input  logic                  memwb_uses_rd,
    input  logic                  memwb_wr_en,
    output logic [1:0]            fwd_a_sel,
    output logic [1:0]            fwd_b_sel,
    output logic                  pc_hold,
    output logic                  ifid_hold,
    output logic                  idex_bubble
);
    localparam int AW = REG_ADDR_W;
    localparam int P_IDEX  = 0;
    localparam int P_EXMEM = 1;
    localparam int P_MEMWB = 2;

    logic [AW-1:0] rd_arr  [N_PRODUCERS];
    logic [AW-1:0] rt_arr  [N_PRODUCERS];
    logic          ud_arr  [N_PRODUCERS];
    logic [AW-1:0] dest_arr[N_PRODUCERS];
    logic [AW-1:0] src_arr [N_OPERANDS];
    opnd_src_e     sel_arr [N_OPERANDS];
    logic          stall;

    always_comb begin
        rd_arr[P_IDEX]  = idex_rd;   rt_arr[P_IDEX]  = idex_rt;   ud_arr[P_IDEX]  = idex_uses_rd;
        rd_arr[P_EXMEM] = exmem_rd;  rt_arr[P_EXMEM] = exmem_rt;  ud_arr[P_EXMEM] = exmem_uses_rd;
        rd_arr[P_MEMWB] = memwb_rd;  rt_arr[P_MEMWB] = memwb_rt;  ud_arr[P_MEMWB] = memwb_uses_rd;
        src_arr[0] = ex_rs;
        src_arr[1] = ex_rt;
    end

    for (genvar p = 0; p < N_PRODUCERS; p++) begin : g_dest
        fwd_dest_pick #(.AW(AW)) u_pick (
            .rd_fld  (rd_arr[p]),
            .rt_fld  (rt_arr[p]),
            .uses_rd (ud_arr[p]),
            .dest    (dest_arr[p])
        );
    end

    for (genvar k = 0; k < N_OPERANDS; k++) begin : g_opnd
        fwd_src_sel #(.AW(AW)) u_sel (
            .src           (src_arr[k]),
            .exmem_dest    (dest_arr[P_EXMEM]),
            .exmem_wr_en   (exmem_wr_en),
            .exmem_is_load (exmem_is_load),
            .memwb_dest    (dest_arr[P_MEMWB]),
            .memwb_wr_en   (memwb_wr_en),
            .sel           (sel_arr[k])
        );
    end

    fwd_interlock #(.AW(AW)) u_lock (
        .idex_dest    (dest_arr[P_IDEX]),
        .idex_wr_en   (idex_wr_en),
        .idex_is_load (idex_is_load),
        .id_rs        (id_rs),
        .id_rt        (id_rt),
        .stall        (stall)
    );

    always_comb begin
        fwd_a_sel   = sel_arr[0];
        fwd_b_sel   = sel_arr[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end

    // Checks on the assembled outputs against the raw port fields
    always_comb begin
        p_sel_a_legal_r4: assert (fwd_a_sel != 2'd3) else $error("illegal select A");
        p_sel_b_legal_r4: assert (fwd_b_sel != 2'd3) else $error("illegal select B");
        if (exmem_is_load) begin
            p_no_load_bypass_r10: assert (fwd_a_sel != 2'd1 && fwd_b_sel != 2'd1)
                else $error("load in execute/memory used as bypass");
        end
        if (pc_hold) begin
            p_stall_needs_load_r7: assert (idex_is_load && idex_wr_en)
                else $error("stall without a writing load in decode/execute");
        end
        if (fwd_a_sel == 2'd1) begin
            p_exmem_hit_a_r1: assert (exmem_wr_en && ex_rs != '0)
                else $error("execute/memory bypass without a write");
        end
    end
endmodule

// File: tb/fwd_hazard_ctrl_test.sv
module fwd_hazard_ctrl_test;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;  // 125 MHz

    logic [AW-1:0] ex_rs, ex_rt, id_rs, id_rt;
    logic [AW-1:0] idex_rd, idex_rt, exmem_rd, exmem_rt, memwb_rd, memwb_rt;
    logic idex_uses_rd, idex_wr_en, idex_is_load;
    logic exmem_uses_rd, exmem_wr_en, exmem_is_load;
    logic memwb_uses_rd, memwb_wr_en;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic pc_hold, ifid_hold, idex_bubble;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    fwd_hazard_ctrl #(.REG_ADDR_W(AW)) uut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .id_rs(id_rs), .id_rt(id_rt),
        .idex_rd(idex_rd), .idex_rt(idex_rt), .idex_uses_rd(idex_uses_rd),
        .idex_wr_en(idex_wr_en), .idex_is_load(idex_is_load),
        .exmem_rd(exmem_rd), .exmem_rt(exmem_rt), .exmem_uses_rd(exmem_uses_rd),
        .exmem_wr_en(exmem_wr_en), .exmem_is_load(exmem_is_load),
        .memwb_rd(memwb_rd), .memwb_rt(memwb_rt), .memwb_uses_rd(memwb_uses_rd),
        .memwb_wr_en(memwb_wr_en),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    // Behavioural reference
    function automatic int dest_of(int rd, int rt, bit urd);
        return urd ? rd : rt;
    endfunction

    function automatic int ref_sel(int src);
        int em = dest_of(exmem_rd, exmem_rt, exmem_uses_rd);
        int mw = dest_of(memwb_rd, memwb_rt, memwb_uses_rd);
        if (src == 0) return 0;
        if (exmem_wr_en && !exmem_is_load && em == src) return 1;
        if (memwb_wr_en && mw == src) return 2;
        return 0;
    endfunction

    function automatic bit ref_stall();
        int d = dest_of(idex_rd, idex_rt, idex_uses_rd);
        if (!(idex_is_load && idex_wr_en) || d == 0) return 0;
        return (d == id_rs) || (d == id_rt);
    endfunction

    task automatic clear_all();
        {ex_rs, ex_rt, id_rs, id_rt} = '0;
        {idex_rd, idex_rt, exmem_rd, exmem_rt, memwb_rd, memwb_rt} = '0;
        {idex_uses_rd, idex_wr_en, idex_is_load} = '0;
        {exmem_uses_rd, exmem_wr_en, exmem_is_load} = '0;
        {memwb_uses_rd, memwb_wr_en} = '0;
    endtask

    task automatic check(string tag);
        int ea = ref_sel(ex_rs);
        int eb = ref_sel(ex_rt);
        bit es = ref_stall();
        @(negedge clk);
        n_tests++;
        if (fwd_a_sel != ea[1:0] || fwd_b_sel != eb[1:0] ||
            pc_hold != es || ifid_hold != es || idex_bubble != es) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d hold=%0d/%0d bub=%0d expected a=%0d b=%0d stall=%0d",
                     tag, fwd_a_sel, fwd_b_sel, pc_hold, ifid_hold, idex_bubble, ea, eb, es);
        end
    endtask

    task automatic expect_val(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R4: idle pipeline
        @(posedge clk); clear_all(); check("R4 idle");
        expect_val("R4 idle select A", fwd_a_sel, 0);

        // R1/R6: reg-reg producer in execute/memory writes rd
        @(posedge clk); clear_all();
        exmem_rd = 3; exmem_rt = 8; exmem_uses_rd = 1; exmem_wr_en = 1; ex_rs = 3;
        check("R1 exmem rd hit");
        expect_val("R1 select A", fwd_a_sel, 1);

        // R2/R6: immediate producer in memory/write-back writes rt
        @(posedge clk); clear_all();
        memwb_rd = 11; memwb_rt = 5; memwb_wr_en = 1; ex_rt = 5;
        check("R2 memwb rt hit");
        expect_val("R2 select B", fwd_b_sel, 2);

        // R3: both match
        @(posedge clk); clear_all();
        exmem_rd = 7; exmem_uses_rd = 1; exmem_wr_en = 1;
        memwb_rd = 7; memwb_uses_rd = 1; memwb_wr_en = 1; ex_rs = 7; ex_rt = 7;
        check("R3 priority");
        expect_val("R3 select A", fwd_a_sel, 1);

        // R5: register 0 everywhere
        @(posedge clk); clear_all();
        exmem_wr_en = 1; memwb_wr_en = 1; idex_wr_en = 1; idex_is_load = 1;
        check("R5 zero register");
        expect_val("R5 no stall", pc_hold, 0);

        // R6: match only on the unused field
        @(posedge clk); clear_all();
        exmem_rd = 2; exmem_rt = 9; exmem_uses_rd = 1; exmem_wr_en = 1; ex_rs = 9;
        check("R6 unused field");
        expect_val("R6 select A", fwd_a_sel, 0);

        // R7: load-use on decode rt, then the follow-up cycle bypasses from memory/write-back
        @(posedge clk); clear_all();
        idex_rt = 4; idex_wr_en = 1; idex_is_load = 1; id_rt = 4; id_rs = 1;
        check("R7 load-use stall");
        expect_val("R7 bubble", idex_bubble, 1);
        @(posedge clk); clear_all();
        memwb_rt = 4; memwb_wr_en = 1; ex_rt = 4; id_rs = 4;
        check("R7 after stall");
        expect_val("R7 bypass after stall", fwd_b_sel, 2);

        // R8: non-load producer does not stall
        @(posedge clk); clear_all();
        idex_rd = 6; idex_uses_rd = 1; idex_wr_en = 1; id_rs = 6;
        check("R8 alu no stall");
        expect_val("R8 hold", ifid_hold, 0);

        // R9: write enable clear
        @(posedge clk); clear_all();
        exmem_rd = 3; exmem_uses_rd = 1; memwb_rt = 3; idex_rt = 3; idex_is_load = 1;
        ex_rs = 3; ex_rt = 3; id_rs = 3;
        check("R9 no write");

        // R10: load in execute/memory is not a bypass source
        @(posedge clk); clear_all();
        exmem_rt = 6; exmem_wr_en = 1; exmem_is_load = 1; ex_rs = 6;
        check("R10 load not bypassed");
        expect_val("R10 select A", fwd_a_sel, 0);

        // Random sweep: every cycle compared with the model (R1..R10)
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
            id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
            idex_rd = AW'($urandom_range(0, 3)); idex_rt = AW'($urandom_range(0, 3));
            exmem_rd = AW'($urandom_range(0, 3)); exmem_rt = AW'($urandom_range(0, 3));
            memwb_rd = AW'($urandom_range(0, 3)); memwb_rt = AW'($urandom_range(0, 3));
            {idex_uses_rd, idex_wr_en, idex_is_load} = 3'($urandom);
            {exmem_uses_rd, exmem_wr_en, exmem_is_load} = 3'($urandom);
            {memwb_uses_rd, memwb_wr_en} = 2'($urandom);
            check("random R1 R2 R3 R7");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule